// File: doc/BRIEF.md
# Framed Synchronous Serial Byte Transmitter

This block sends a stream of bytes to a host's synchronous serial receiver over three wires: a bit clock, a frame-sync strobe and a serial data line. Bytes enter through a ready/valid handshake. Each accepted byte becomes one frame. The frame-sync line is high for the first bit period of the frame, and the data bits follow most significant bit first. The host takes both its receive and its transmit timing from this one clock and sync pair.

The bit clock comes from the system clock through a divider whose half period is a parameter. The data and sync lines change only in the system-clock cycle where the bit clock falls. The receiver can therefore sample them on the rising edge. When a frame ends and no byte is waiting, the line goes idle: sync stays low and data stays at 0 until the next byte arrives.

Top module: `sync_frame_tx`

## Requirements
- R1: `ser_clk` is low after reset. It then toggles every `HALF` system-clock cycles, so the rising edges are `2*HALF` cycles apart and each high phase lasts `HALF` cycles.
- R2: While `rst_n` is low, and in the first cycle after it is released, `ser_clk`, `ser_sync`, `ser_data` and `in_ready` are all 0.
- R3: Each accepted byte is sent as exactly `W` (default 8) bits on `ser_data`, most significant bit first, one bit per bit period. The receiver samples each bit on a rising edge of `ser_clk`.
- R4: `ser_sync` is high for exactly one bit period per frame, the period that carries the first (most significant) bit. It is never high during the other bits of a frame.
- R5: `ser_data` and `ser_sync` change only in the system-clock cycle where `ser_clk` falls.
- R6: `in_ready` is a one-cycle pulse. It is issued only in the cycle just before a falling bit-clock edge that ends either the last bit of a frame or an idle bit period. It never occurs while a frame still has bits left to send.
- R7: When a byte is accepted at the end of a frame, the next frame's sync period immediately follows the previous frame's last bit. Sync periods of back-to-back frames are exactly `W` bit periods apart.
- R8: In any bit period that belongs to no frame, `ser_sync` is 0 and `ser_data` is 0.
- R9: A byte is taken only in a cycle where `in_valid` and `in_ready` are both high. Changes to `in_data` at any other time have no effect on the transmitted bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Source offers a byte |
| in_data | input | W | Byte offered by the source |
| in_ready | output | 1 | One-cycle acceptance slot at a word boundary |
| ser_clk | output | 1 | Divided bit clock to the host |
| ser_sync | output | 1 | Frame-sync strobe, high during the first bit |
| ser_data | output | 1 | Serial data, MSB first |

## Verification
The assertions assume the source follows ready/valid rules. `in_data` is sampled only in the cycle of a transfer, and the reset is held low for at least one clock edge before any check applies. The driver keeps to this. It changes `in_valid` and `in_data` only on falling system-clock edges, and it treats a byte as taken only after it has seen `in_ready` and `in_valid` high together. Outside transfers it deliberately scrambles `in_data`, and during back-to-back bursts it holds a new byte while the current frame is still shifting. Either way the design is never handed a byte outside an acceptance slot.

// File: rtl/sft_pkg.sv
// Shared definitions for the framed synchronous transmitter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sft_pkg;

    // Default serial word width in bits.
    localparam int SFT_DEF_WORD_W = 8;

    // Default system-clock cycles per half bit period.
    localparam int SFT_DEF_HALF = 3;

    // Word sequencer state.
    typedef enum logic {
        SFT_IDLE = 1'b0,
        SFT_SEND = 1'b1
    } sft_state_e;

endpackage

// File: rtl/sft_clkdiv.sv
// Bit-clock divider.
// Produces the serial bit clock by toggling every HALF system cycles. It also
// produces a strobe in the system cycle just before each falling bit-clock
// edge; all output transitions of the transmitter are tied to that strobe.
// Assumes HALF >= 1.
module sft_clkdiv #(
    parameter int HALF = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic ser_clk,
    output logic fall_stb
);

    logic term;
    logic sclk_q;

    generate
        if (HALF == 1) begin : g_nodiv
            // Every cycle is a terminal cycle; no counter needed.
            assign term = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(HALF);
            localparam logic [CW-1:0] LAST = CW'(HALF - 1);
            logic [CW-1:0] cnt;

            // Count system cycles inside one half bit period.
            always_ff @(posedge clk) begin
                if (!rst_n)           cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                  cnt <= cnt + 1'b1;
            end

            assign term = (cnt == LAST);
        end
    endgenerate

    // Toggle the bit clock at the end of each half period.
    always_ff @(posedge clk) begin
        if (!rst_n)    sclk_q <= 1'b0;
        else if (term) sclk_q <= ~sclk_q;
    end

    assign ser_clk  = sclk_q;
    assign fall_stb = term && sclk_q;

    // R1
    sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !term |=> $stable(sclk_q));

endmodule

// File: rtl/sft_seq.sv
// Word sequencer.
// Tracks the bit position within the current frame and decides, at each
// falling bit-clock strobe, whether to shift, to start a new word or to idle.
// The acceptance slot (in_ready) opens only at a word boundary, for the one
// system cycle of the falling strobe.
// Assumes W >= 2.
module sft_seq
    import sft_pkg::*;
#(
    parameter int W = SFT_DEF_WORD_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_stb,
    input  logic in_valid,
    output logic in_ready,
    output logic load,
    output logic shift,
    output logic busy
);

    localparam int IW = $clog2(W);
    localparam logic [IW-1:0] LAST_IDX = IW'(W - 1);

    sft_state_e    state;
    logic [IW-1:0] idx;
    logic          boundary;

    // A boundary is an idle period or the last bit of a frame.
    assign boundary = (state == SFT_IDLE) || (idx == LAST_IDX);
    assign in_ready = fall_stb && boundary;
    assign load     = in_ready && in_valid;
    assign shift    = fall_stb && !boundary;
    assign busy     = (state == SFT_SEND);

    // Advance the frame position on each falling strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SFT_IDLE;
            idx   <= '0;
        end else if (load) begin
            state <= SFT_SEND;
            idx   <= '0;
        end else if (in_ready) begin
            state <= SFT_IDLE;
            idx   <= '0;
        end else if (shift) begin
            idx   <= idx + 1'b1;
        end
    end

    // R7
    reload_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && idx == '0));

endmodule

// File: rtl/sft_shifter.sv
// Output shift register and frame-sync flop.
// Loads a word with sync raised, shifts left (MSB leaves first) with sync
// lowered, and clears both when a strobe passes with neither load nor shift.
// Assumes load and shift only occur together with fall_stb.
module sft_shifter
    import sft_pkg::*;
#(
    parameter int W = SFT_DEF_WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fall_stb,
    input  logic         load,
    input  logic         shift,
    input  logic         busy,
    input  logic [W-1:0] in_data,
    output logic         ser_sync,
    output logic         ser_data
);

    logic [W-1:0] shreg;
    logic         sync_q;

    // Load, shift or clear the outgoing word on the falling strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            sync_q <= 1'b0;
        end else if (load) begin
            shreg  <= in_data;
            sync_q <= 1'b1;
        end else if (shift) begin
            shreg  <= {shreg[W-2:0], 1'b0};
            sync_q <= 1'b0;
        end else if (fall_stb) begin
            shreg  <= '0;
            sync_q <= 1'b0;
        end
    end

    assign ser_data = shreg[W-1];
    assign ser_sync = sync_q;

    // R5
    edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_stb |=> ($stable(shreg) && $stable(sync_q)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sync_q && !ser_data));

endmodule

// File: rtl/sync_frame_tx.sv
// Framed synchronous byte transmitter (top).
// Accepts bytes over ready/valid and sends each as one frame: sync high for
// the MSB period, then the remaining bits, all changing on the falling edge
// of a divided bit clock. Assumes a standard ready/valid source.
module sync_frame_tx
    import sft_pkg::*;
#(
    parameter int W    = SFT_DEF_WORD_W,
    parameter int HALF = SFT_DEF_HALF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         ser_clk,
    output logic         ser_sync,
    output logic         ser_data
);

    logic fall_stb;
    logic load;
    logic shift;
    logic busy;

    sft_clkdiv #(.HALF(HALF)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .fall_stb (fall_stb)
    );

    sft_seq #(.W(W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_stb (fall_stb),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .load     (load),
        .shift    (shift),
        .busy     (busy)
    );

    sft_shifter #(.W(W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_stb (fall_stb),
        .load     (load),
        .shift    (shift),
        .busy     (busy),
        .in_data  (in_data),
        .ser_sync (ser_sync),
        .ser_data (ser_data)
    );

    // R3
    accept_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> (ser_sync && ser_data == $past(in_data[W-1])));

endmodule

// File: tb/sync_frame_tx_test.sv
// Scoreboard bench: the driver queues accepted bytes, the monitor rebuilds
// frames at rising bit-clock edges and compares.
module sync_frame_tx_test;

    localparam int W    = 8;
    localparam int HALF = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_ready;
    logic         ser_clk;
    logic         ser_sync;
    logic         ser_data;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] exp_q[$];
    int  words_seen = 0;
    bit  b2b_mode = 1'b0;
    bit  mon_on = 1'b0;
    int  idle_checks = 0;

    always #10 clk = ~clk;

    sync_frame_tx #(.W(W), .HALF(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .ser_clk(ser_clk), .ser_sync(ser_sync),
        .ser_data(ser_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Driver: offer a byte, wait for the slot, record it as expected.
    task automatic send_byte(input logic [W-1:0] b, input bit hold);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        exp_q.push_back(b);
        @(negedge clk);
        if (!hold) begin
            in_valid = 1'b0;
            in_data  = ~b;   // R9: scrambled outside a transfer
        end
    endtask

    // Monitor state
    int   cyc = 0;
    logic prev_clk = 1'b0, prev_sync = 1'b0, prev_dat = 1'b0;
    int   last_rise = -1, last_fall = -1;
    int   period_idx = 0, last_start = -1;
    int   nbits = 0;
    bit   collecting = 1'b0;
    logic [W-1:0] word;

    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            // R5: serial lines move only when the bit clock has just fallen
            if ((ser_sync !== prev_sync) || (ser_data !== prev_dat))
                check(!ser_clk && prev_clk, "R5 change off falling edge", ser_clk, 0);
            // R6: slot only at boundaries, just before a fall
            if (in_ready) begin
                check(ser_clk && !collecting, "R6 ready placement", {collecting, ser_clk}, 1);
            end
            // R1: high-phase length at each fall
            if (!ser_clk && prev_clk && last_rise >= 0) begin
                check(cyc - last_rise == HALF, "R1 high phase", cyc - last_rise, HALF);
                last_fall = cyc;
            end
            if (ser_clk && !prev_clk) begin
                if (last_rise >= 0)
                    check(cyc - last_rise == 2*HALF, "R1 period", cyc - last_rise, 2*HALF);
                last_rise = cyc;
                period_idx++;
                if (ser_sync) begin
                    // R4: sync must not appear inside a frame
                    check(!collecting, "R4 sync mid-frame", nbits, W);
                    if (b2b_mode && last_start >= 0)
                        check(period_idx - last_start == W, "R7 frame spacing",
                              period_idx - last_start, W);
                    last_start = period_idx;
                    collecting = 1'b1;
                    nbits = 1;
                    word = {{(W-1){1'b0}}, ser_data};
                end else if (collecting) begin
                    nbits++;
                    word = {word[W-2:0], ser_data};
                    if (nbits == W) begin
                        collecting = 1'b0;
                        words_seen++;
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R3 unexpected frame", word, 0);
                        end else begin
                            logic [W-1:0] e;
                            e = exp_q.pop_front();
                            check(word == e, "R3 frame content", word, e);
                        end
                    end
                end else begin
                    // R8: idle bit period
                    idle_checks++;
                    check(!ser_data, "R8 idle data", ser_data, 0);
                end
            end
        end
        prev_clk  = ser_clk;
        prev_sync = ser_sync;
        prev_dat  = ser_data;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: outputs during reset
        check({ser_clk, ser_sync, ser_data, in_ready} == 4'b0, "R2 reset outputs",
              {ser_clk, ser_sync, ser_data, in_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: first cycle after release
        check({ser_clk, ser_sync, ser_data, in_ready} == 4'b0, "R2 after release",
              {ser_clk, ser_sync, ser_data, in_ready}, 0);
        mon_on = 1'b1;
        last_rise = -1;

        // Idle line for a few bit periods (R8)
        repeat (6 * 2 * HALF) @(negedge clk);

        // Single byte (R3, R4, R9)
        send_byte(8'hA5, 1'b0);
        repeat (12 * 2 * HALF) @(negedge clk);

        // Byte offered in mid-idle, then held early by the source (R6, R9)
        repeat (HALF) @(negedge clk);
        send_byte(8'h5A, 1'b0);
        repeat (3 * 2 * HALF) @(negedge clk);

        // Back-to-back burst (R7), new byte held while previous one shifts
        b2b_mode = 1'b1;
        send_byte(8'h80, 1'b1);
        send_byte(8'h01, 1'b1);
        send_byte(8'hFF, 1'b1);
        send_byte(8'h00, 1'b1);
        send_byte(8'h3C, 1'b0);
        repeat (12 * 2 * HALF) @(negedge clk);
        b2b_mode = 1'b0;

        // Two bytes with a gap of several idle periods
        send_byte(8'hC3, 1'b0);
        repeat (15 * 2 * HALF) @(negedge clk);
        send_byte(8'h7E, 1'b0);
        repeat (12 * 2 * HALF) @(negedge clk);

        // R3: every queued byte came out as a frame
        check(exp_q.size() == 0, "R3 all frames delivered", exp_q.size(), 0);
        check(words_seen == 9, "R3 frame count", words_seen, 9);
        // R8: idle periods were observed
        check(idle_checks > 0, "R8 idle periods seen", idle_checks, 1);
        finish_run();
    end

endmodule